// File: doc/BRIEF.md
# SECDED Memory Word Protector

This block sits between a bus-side memory port and a single-port RAM whose words are 39 bits wide. On a write it stores the 32 data bits unchanged in bits 31:0 of the codeword and adds seven check bits above them: six Hamming bits in 37:32 and an overall parity bit in 38. On a read it decodes the returned codeword one clock later. It corrects any single flipped bit and marks any two flipped bits as uncorrectable.

A two-bit policy field sets how each error class is reported. Policy 0 turns checking off. Policy 1 corrects single errors silently and reports double errors. Policy 2 also raises a sticky flag for single errors. Policy 3 also raises an event for single errors. A routing bit sends every event either to a one-cycle non-maskable interrupt pulse or to a one-cycle reset request. The block also holds sticky status flags, the word address of the last detected error, and a test injector that flips one chosen codeword bit on the write path.

Configuration writes are guarded by a two-state lock machine. The states are `LK_SHUT` (the reset state) and `LK_OPEN`. Transition UNLOCK goes from `LK_SHUT` to `LK_OPEN` when key 0x77 is written to the key register. Transition RELOCK goes from `LK_OPEN` to `LK_SHUT` when key 0x76 is written. Any other key value leaves the state as it is.

Top module: `ecc_sram_guard`

## Requirements
- R1: Each bus write issues a RAM write in the same cycle with `ram_wdata[31:0]` equal to `bus_wdata`. A word written with injection off reads back with its data intact and with no error tag, flag or event.
- R2: `rd_valid` and `rd_data` appear exactly one clock after `ram_rvalid`. `rd_valid` is low in every other cycle.
- R3: With policy 1, 2 or 3, a single flipped bit at any of the 39 codeword positions returns the original data with `rd_err_fixed` high and `rd_err_fatal` low.
- R4: With policy 1, 2 or 3, two flipped bits return the raw, uncorrected data bits with `rd_err_fatal` high. They also set status bit 1.
- R5: With policy 0, read data is returned raw. No error tag, status flag, event or address capture occurs.
- R6: Status bit 0 (single error) is set only under policies 2 and 3. Single errors raise an event only under policy 3. Double errors raise an event under policies 1, 2 and 3.
- R7: Control bit 2 routes events: 0 selects `nmi_pulse` and 1 selects `reset_req`. Each event is a one-cycle pulse in the same cycle as the `rd_valid` of the failing read, and the two outputs are never high together.
- R8: Injection register (select 2) fields: bit 0 is enable, bit 1 is range, bits 6:2 are the bit number. Range 0 flips codeword bit n. Range 1 flips codeword bit 32+n for n from 0 to 6 and flips nothing for larger n. Nothing is flipped while enable is 0.
- R9: Register select 4 returns the word address of the most recent read in which an error was detected under policy 1, 2 or 3.
- R10: The block resets into `LK_SHUT`, and register select 0 reads bit 0 as 1 only in `LK_OPEN`. In `LK_SHUT`, writes to control (select 1: bits 1:0 policy, bit 2 route) and injection (select 2) are ignored.
- R11: Status register (select 3) bits are sticky and are cleared by writing 1 to them. This works in either lock state, and a new set in the same cycle wins over the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_req | input | 1 | Bus access request |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | AW | Word address |
| bus_wdata | input | 32 | Write data |
| rd_valid | output | 1 | Read result valid |
| rd_data | output | 32 | Read data |
| rd_err_fixed | output | 1 | Read had a corrected single error |
| rd_err_fatal | output | 1 | Read had an uncorrectable error |
| ram_en | output | 1 | RAM access enable |
| ram_we | output | 1 | RAM write enable |
| ram_addr | output | AW | RAM word address |
| ram_wdata | output | 39 | Codeword to RAM |
| ram_rvalid | input | 1 | RAM read data valid |
| ram_rdata | input | 39 | Codeword from RAM |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 3 | Register select |
| cfg_wdata | input | 8 | Register write data |
| cfg_rdata | output | 16 | Selected register contents |
| nmi_pulse | output | 1 | Error event, interrupt route |
| reset_req | output | 1 | Error event, reset route |

## Verification
The assertions assume that `ram_rvalid` answers the most recent read request one clock after it was issued, with no read outstanding beyond that. They also assume that the policy field does not change between a RAM response and the decoded result. The stimulus waits for each read to return before issuing the next access and changes configuration only between reads. Bit corruption is applied to the behavioural memory only while no access is in flight.

// File: rtl/eccg_pkg.sv
package eccg_pkg;

    localparam int DW    = 32;
    localparam int HW    = 6;
    localparam int WW    = 39;
    localparam int CFG_W = 16;

    typedef enum logic [1:0] {
        MODE_OFF   = 2'd0,
        MODE_QUIET = 2'd1,
        MODE_FLAG  = 2'd2,
        MODE_LOUD  = 2'd3
    } ecc_mode_e;

    typedef enum logic [2:0] {
        REG_KEY  = 3'd0,
        REG_CTRL = 3'd1,
        REG_INJ  = 3'd2,
        REG_STAT = 3'd3,
        REG_ADDR = 3'd4
    } reg_sel_e;

    typedef enum logic {
        LK_SHUT = 1'b0,
        LK_OPEN = 1'b1
    } lock_state_e;

    localparam logic [7:0] KEY_OPEN = 8'h77;
    localparam logic [7:0] KEY_SHUT = 8'h76;

    // Hamming position (3..38, skipping powers of two) of data bit idx
    function automatic logic [5:0] data_pos(input int idx);
        int cnt;
        logic [5:0] pos;
        cnt = 0;
        pos = '0;
        for (int q = 3; q < WW; q++) begin
            if ((q & (q - 1)) != 0) begin
                if (cnt == idx) pos = 6'(q);
                cnt++;
            end
        end
        return pos;
    endfunction

    // XOR of the positions of all set data bits
    function automatic logic [HW-1:0] pos_sum(input logic [DW-1:0] d);
        logic [HW-1:0] s;
        s = '0;
        for (int i = 0; i < DW; i++) begin
            if (d[i]) s = s ^ data_pos(i);
        end
        return s;
    endfunction

    function automatic logic [WW-1:0] encode(input logic [DW-1:0] d);
        logic [HW-1:0] c;
        c = pos_sum(d);
        return {^{d, c}, c, d};
    endfunction

endpackage

// File: rtl/eccg_wpath.sv
module eccg_wpath
    import eccg_pkg::*;
#(
    parameter int AW = 10
) (
    input  logic          bus_req,
    input  logic          bus_we,
    input  logic [AW-1:0] bus_addr,
    input  logic [DW-1:0] bus_wdata,
    input  logic          inj_en,
    input  logic          inj_hi,
    input  logic [4:0]    inj_bit,
    output logic          ram_en,
    output logic          ram_we,
    output logic [AW-1:0] ram_addr,
    output logic [WW-1:0] ram_wdata
);

    localparam logic [4:0] HI_SPAN = 5'(WW - DW);

    logic [WW-1:0] flip;

    always_comb begin
        flip = '0;
        if (inj_en) begin
            if (!inj_hi) begin
                flip[inj_bit] = 1'b1;
            end else if (inj_bit < HI_SPAN) begin
                flip[6'(inj_bit) + 6'(DW)] = 1'b1;
            end
        end
    end

    assign ram_en    = bus_req;
    assign ram_we    = bus_we;
    assign ram_addr  = bus_addr;
    assign ram_wdata = encode(bus_wdata) ^ flip;

endmodule

// File: rtl/eccg_rpath.sv
module eccg_rpath
    import eccg_pkg::*;
#(
    parameter int AW = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rd_issue,
    input  logic [AW-1:0] rd_issue_addr,
    input  logic          ram_rvalid,
    input  logic [WW-1:0] ram_rdata,
    input  ecc_mode_e     mode,
    input  logic          route_rst,
    output logic          rd_valid,
    output logic [DW-1:0] rd_data,
    output logic          rd_err_fixed,
    output logic          rd_err_fatal,
    output logic          nmi_pulse,
    output logic          reset_req,
    output logic          set_single,
    output logic          set_double,
    output logic          cap_en,
    output logic [AW-1:0] cap_addr
);

    logic [AW-1:0] pend_q;
    logic [HW-1:0] syn;
    logic          odd;
    logic          one_err;
    logic          two_err;
    logic          chk_on;
    logic          evt;
    logic [DW-1:0] fixd;
    logic [DW-1:0] dout;

    assign syn     = ram_rdata[WW-2:DW] ^ pos_sum(ram_rdata[DW-1:0]);
    assign odd     = ^ram_rdata;
    assign one_err = odd && (syn <= 6'(WW - 1));
    assign two_err = (!odd && syn != '0) || (odd && syn > 6'(WW - 1));
    assign chk_on  = (mode != MODE_OFF);

    for (genvar gi = 0; gi < DW; gi++) begin : g_fix
        localparam logic [5:0] POS = data_pos(gi);
        assign fixd[gi] = ram_rdata[gi] ^ (syn == POS);
    end

    assign dout       = (!chk_on || two_err) ? ram_rdata[DW-1:0] : fixd;
    assign set_single = ram_rvalid && one_err && (mode == MODE_FLAG || mode == MODE_LOUD);
    assign set_double = ram_rvalid && two_err && chk_on;
    assign evt        = set_double || (ram_rvalid && one_err && mode == MODE_LOUD);
    assign cap_en     = ram_rvalid && chk_on && (one_err || two_err);
    assign cap_addr   = pend_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q       <= '0;
            rd_valid     <= 1'b0;
            rd_data      <= '0;
            rd_err_fixed <= 1'b0;
            rd_err_fatal <= 1'b0;
            nmi_pulse    <= 1'b0;
            reset_req    <= 1'b0;
        end else begin
            if (rd_issue) pend_q <= rd_issue_addr;
            rd_valid     <= ram_rvalid;
            rd_err_fixed <= ram_rvalid && chk_on && one_err;
            rd_err_fatal <= ram_rvalid && chk_on && two_err;
            nmi_pulse    <= evt && !route_rst;
            reset_req    <= evt && route_rst;
            if (ram_rvalid) rd_data <= dout;
        end
    end

endmodule

// File: rtl/eccg_regs.sv
module eccg_regs
    import eccg_pkg::*;
#(
    parameter int AW = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [2:0]       cfg_sel,
    input  logic [7:0]       cfg_wdata,
    input  logic             set_single,
    input  logic             set_double,
    input  logic             cap_en,
    input  logic [AW-1:0]    cap_addr,
    output logic [CFG_W-1:0] cfg_rdata,
    output ecc_mode_e        mode,
    output logic             route_rst,
    output logic             inj_en,
    output logic             inj_hi,
    output logic [4:0]       inj_bit,
    output logic             lock_open
);

    lock_state_e   lk_q, lk_d;
    reg_sel_e      sel;
    logic          key_wr;
    logic          wr_ok;
    logic          flag1_q, flag2_q;
    logic [AW-1:0] addr_q;

    assign sel       = reg_sel_e'(cfg_sel);
    assign key_wr    = cfg_we && sel == REG_KEY;
    assign lock_open = (lk_q == LK_OPEN);
    assign wr_ok     = cfg_we && lock_open;

    // lock machine: next state
    always_comb begin
        lk_d = lk_q;
        unique case (lk_q)
            LK_SHUT: if (key_wr && cfg_wdata == KEY_OPEN) lk_d = LK_OPEN;
            LK_OPEN: if (key_wr && cfg_wdata == KEY_SHUT) lk_d = LK_SHUT;
        endcase
    end

    // lock machine: state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lk_q <= LK_SHUT;
        else        lk_q <= lk_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode      <= MODE_OFF;
            route_rst <= 1'b0;
            inj_en    <= 1'b0;
            inj_hi    <= 1'b0;
            inj_bit   <= '0;
            flag1_q   <= 1'b0;
            flag2_q   <= 1'b0;
            addr_q    <= '0;
        end else begin
            if (wr_ok && sel == REG_CTRL) begin
                mode      <= ecc_mode_e'(cfg_wdata[1:0]);
                route_rst <= cfg_wdata[2];
            end
            if (wr_ok && sel == REG_INJ) begin
                inj_en  <= cfg_wdata[0];
                inj_hi  <= cfg_wdata[1];
                inj_bit <= cfg_wdata[6:2];
            end
            flag1_q <= set_single || (flag1_q && !(cfg_we && sel == REG_STAT && cfg_wdata[0]));
            flag2_q <= set_double || (flag2_q && !(cfg_we && sel == REG_STAT && cfg_wdata[1]));
            if (cap_en) addr_q <= cap_addr;
        end
    end

    // register readback
    always_comb begin
        cfg_rdata = '0;
        unique case (sel)
            REG_KEY:  cfg_rdata[0]    = lock_open;
            REG_CTRL: cfg_rdata[2:0]  = {route_rst, mode};
            REG_INJ:  cfg_rdata[6:0]  = {inj_bit, inj_hi, inj_en};
            REG_STAT: cfg_rdata[1:0]  = {flag2_q, flag1_q};
            REG_ADDR: cfg_rdata[AW-1:0] = addr_q;
            default:  cfg_rdata = '0;
        endcase
    end

endmodule

// File: rtl/ecc_sram_guard.sv
module ecc_sram_guard
    import eccg_pkg::*;
#(
    parameter int AW = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_req,
    input  logic             bus_we,
    input  logic [AW-1:0]    bus_addr,
    input  logic [31:0]      bus_wdata,
    output logic             rd_valid,
    output logic [31:0]      rd_data,
    output logic             rd_err_fixed,
    output logic             rd_err_fatal,
    output logic             ram_en,
    output logic             ram_we,
    output logic [AW-1:0]    ram_addr,
    output logic [38:0]      ram_wdata,
    input  logic             ram_rvalid,
    input  logic [38:0]      ram_rdata,
    input  logic             cfg_we,
    input  logic [2:0]       cfg_sel,
    input  logic [7:0]       cfg_wdata,
    output logic [15:0]      cfg_rdata,
    output logic             nmi_pulse,
    output logic             reset_req
);

    ecc_mode_e     mode_w;
    logic          route_w;
    logic          inj_en_w, inj_hi_w;
    logic [4:0]    inj_bit_w;
    logic          lock_open;
    logic          set_single, set_double, cap_en;
    logic [AW-1:0] cap_addr;

    eccg_wpath #(.AW(AW)) u_wpath (
        .bus_req   (bus_req),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .inj_en    (inj_en_w),
        .inj_hi    (inj_hi_w),
        .inj_bit   (inj_bit_w),
        .ram_en    (ram_en),
        .ram_we    (ram_we),
        .ram_addr  (ram_addr),
        .ram_wdata (ram_wdata)
    );

    eccg_rpath #(.AW(AW)) u_rpath (
        .clk           (clk),
        .rst_n         (rst_n),
        .rd_issue      (bus_req && !bus_we),
        .rd_issue_addr (bus_addr),
        .ram_rvalid    (ram_rvalid),
        .ram_rdata     (ram_rdata),
        .mode          (mode_w),
        .route_rst     (route_w),
        .rd_valid      (rd_valid),
        .rd_data       (rd_data),
        .rd_err_fixed  (rd_err_fixed),
        .rd_err_fatal  (rd_err_fatal),
        .nmi_pulse     (nmi_pulse),
        .reset_req     (reset_req),
        .set_single    (set_single),
        .set_double    (set_double),
        .cap_en        (cap_en),
        .cap_addr      (cap_addr)
    );

    eccg_regs #(.AW(AW)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_we     (cfg_we),
        .cfg_sel    (cfg_sel),
        .cfg_wdata  (cfg_wdata),
        .set_single (set_single),
        .set_double (set_double),
        .cap_en     (cap_en),
        .cap_addr   (cap_addr),
        .cfg_rdata  (cfg_rdata),
        .mode       (mode_w),
        .route_rst  (route_w),
        .inj_en     (inj_en_w),
        .inj_hi     (inj_hi_w),
        .inj_bit    (inj_bit_w),
        .lock_open  (lock_open)
    );

endmodule

// File: rtl/eccg_chk.sv
module eccg_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        ram_rvalid,
    input logic [38:0] ram_rdata,
    input logic        rd_valid,
    input logic [31:0] rd_data,
    input logic        rd_err_fixed,
    input logic        rd_err_fatal,
    input logic        nmi_pulse,
    input logic        reset_req,
    input logic        cfg_we,
    input logic [2:0]  cfg_sel,
    input logic [1:0]  mode_w,
    input logic        lock_open
);

    AST_RD_LATENCY: assert property (@(posedge clk) disable iff (!rst_n) ram_rvalid |=> rd_valid); // R2
    AST_RD_IDLE: assert property (@(posedge clk) disable iff (!rst_n) !ram_rvalid |=> !rd_valid); // R2
    AST_TAGS_EXCL: assert property (@(posedge clk) disable iff (!rst_n) rd_valid |-> !(rd_err_fixed && rd_err_fatal)); // R3
    AST_FATAL_RAW: assert property (@(posedge clk) disable iff (!rst_n) (rd_valid && rd_err_fatal) |-> rd_data == $past(ram_rdata[31:0])); // R4
    AST_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n) (rd_valid && $past(mode_w) == 2'd0) |-> !(rd_err_fixed || rd_err_fatal || nmi_pulse || reset_req)); // R5
    AST_EVT_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !(nmi_pulse && reset_req)); // R7
    AST_EVT_ALIGN: assert property (@(posedge clk) disable iff (!rst_n) (nmi_pulse || reset_req) |-> rd_valid); // R7
    AST_LOCK_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (!lock_open && cfg_we && cfg_sel == 3'd1) |=> $stable(mode_w)); // R10

endmodule

bind ecc_sram_guard eccg_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .ram_rvalid   (ram_rvalid),
    .ram_rdata    (ram_rdata),
    .rd_valid     (rd_valid),
    .rd_data      (rd_data),
    .rd_err_fixed (rd_err_fixed),
    .rd_err_fatal (rd_err_fatal),
    .nmi_pulse    (nmi_pulse),
    .reset_req    (reset_req),
    .cfg_we       (cfg_we),
    .cfg_sel      (cfg_sel),
    .mode_w       (mode_w),
    .lock_open    (lock_open)
);

// File: tb/ecc_sram_guard_bench.sv
module ecc_sram_guard_bench;

    localparam int AW = 10;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_req = 1'b0, bus_we = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [31:0]   bus_wdata = '0;
    logic          rd_valid, rd_err_fixed, rd_err_fatal;
    logic [31:0]   rd_data;
    logic          ram_en, ram_we;
    logic [AW-1:0] ram_addr;
    logic [38:0]   ram_wdata;
    logic          ram_rvalid = 1'b0;
    logic [38:0]   ram_rdata = '0;
    logic          cfg_we = 1'b0;
    logic [2:0]    cfg_sel = '0;
    logic [7:0]    cfg_wdata = '0;
    logic [15:0]   cfg_rdata;
    logic          nmi_pulse, reset_req;

    always #5 clk = ~clk;

    ecc_sram_guard #(.AW(AW)) u_ecc_sram_guard (.*);

    logic [38:0] mem [0:(1<<AW)-1];

    always @(posedge clk) begin
        ram_rvalid <= 1'b0;
        if (ram_en) begin
            if (ram_we) mem[ram_addr] <= ram_wdata;
            else begin
                ram_rdata  <= mem[ram_addr];
                ram_rvalid <= 1'b1;
            end
        end
    end

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    typedef struct {
        logic [31:0] d;
        logic fx, ft, nmi, rs;
        string req;
    } exp_t;
    exp_t exp_q[$];

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // monitor: pops expected results as reads complete
    always @(negedge clk) begin
        if (rst_n) begin
            if (rd_valid) begin
                if (exp_q.size() == 0) begin
                    check("R2 unexpected rd_valid", 32'd1, 32'd0);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    check({e.req, " data"}, rd_data, e.d);
                    check({e.req, " tags"}, {28'd0, rd_err_fixed, rd_err_fatal, nmi_pulse, reset_req},
                          {28'd0, e.fx, e.ft, e.nmi, e.rs});
                end
            end else if (nmi_pulse || reset_req) begin
                check("R7 event without read", {30'd0, nmi_pulse, reset_req}, 32'd0);
            end
        end
    end

    task automatic bus_write(logic [AW-1:0] a, logic [31:0] d);
        @(negedge clk);
        bus_req = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_req = 1'b0; bus_we = 1'b0;
    endtask

    task automatic do_read(logic [AW-1:0] a, logic [31:0] d, logic fx, logic ft,
                           logic nmi, logic rs, string req);
        exp_t e;
        e.d = d; e.fx = fx; e.ft = ft; e.nmi = nmi; e.rs = rs; e.req = req;
        exp_q.push_back(e);
        @(negedge clk);
        bus_req = 1'b1; bus_we = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_req = 1'b0;
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic cfg_write(logic [2:0] s, logic [7:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = s; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic cfg_check(logic [2:0] s, logic [15:0] exp, string req);
        @(negedge clk);
        cfg_sel = s;
        #1;
        check(req, {16'd0, cfg_rdata}, {16'd0, exp});
    endtask

    task automatic flip(logic [AW-1:0] a, int b);
        mem[a][b] = ~mem[a][b];
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        check("R2 reset rd_valid", {31'd0, rd_valid}, 32'd0);
        check("R7 reset events", {30'd0, nmi_pulse, reset_req}, 32'd0);
        cfg_check(3'd0, 16'd0, "R10 reset locked");
        cfg_check(3'd1, 16'd0, "R10 reset ctrl");

        // locked writes ignored
        cfg_write(3'd1, 8'h03);
        cfg_write(3'd2, 8'h35);
        cfg_check(3'd1, 16'd0, "R10 locked ctrl write ignored");
        cfg_check(3'd2, 16'd0, "R10 locked inj write ignored");
        cfg_write(3'd0, 8'h77);
        cfg_check(3'd0, 16'd1, "R10 unlocked");
        cfg_write(3'd1, 8'h01);
        cfg_check(3'd1, 16'd1, "R10 ctrl write accepted");

        // clean round trips, several patterns
        bus_write(10'd1, 32'h0000_0000);
        bus_write(10'd2, 32'hFFFF_FFFF);
        bus_write(10'd3, 32'hA5A5_5A5A);
        bus_write(10'd4, 32'h1234_5678);
        do_read(10'd1, 32'h0000_0000, 0, 0, 0, 0, "R1 clean zeros");
        do_read(10'd2, 32'hFFFF_FFFF, 0, 0, 0, 0, "R1 clean ones");
        do_read(10'd3, 32'hA5A5_5A5A, 0, 0, 0, 0, "R1 clean pattern");
        do_read(10'd4, 32'h1234_5678, 0, 0, 0, 0, "R2 clean count");

        // every single-bit position corrected, policy 1 silent
        bus_write(10'd5, 32'hDEAD_BEEF);
        for (int b = 0; b < 39; b++) begin
            flip(10'd5, b);
            do_read(10'd5, 32'hDEAD_BEEF, 1, 0, 0, 0, "R3 single corrected");
            flip(10'd5, b);
        end
        cfg_check(3'd3, 16'd0, "R6 policy 1 no single flag");

        // double error, policy 1, route to interrupt
        bus_write(10'd6, 32'h0F0F_0F0F);
        flip(10'd6, 3); flip(10'd6, 35);
        do_read(10'd6, 32'h0F0F_0F07, 0, 1, 1, 0, "R4 double raw nmi");
        cfg_check(3'd3, 16'd2, "R4 double flag");
        cfg_check(3'd4, 16'd6, "R9 address captured");

        // W1C works while locked
        cfg_write(3'd0, 8'h76);
        cfg_check(3'd0, 16'd0, "R10 relocked");
        cfg_write(3'd3, 8'h03);
        cfg_check(3'd3, 16'd0, "R11 clear while locked");
        cfg_write(3'd0, 8'h77);

        // policy 2: single sets flag, no event
        cfg_write(3'd1, 8'h02);
        bus_write(10'd7, 32'h5555_AAAA);
        flip(10'd7, 20);
        do_read(10'd7, 32'h5555_AAAA, 1, 0, 0, 0, "R6 policy 2 single no event");
        cfg_check(3'd3, 16'd1, "R6 policy 2 single flag");
        cfg_check(3'd4, 16'd7, "R9 address updated");

        // policy 3 routed to reset
        cfg_write(3'd1, 8'h07);
        bus_write(10'd8, 32'h8000_0001);
        flip(10'd8, 33);
        do_read(10'd8, 32'h8000_0001, 1, 0, 0, 1, "R7 policy 3 single reset");
        flip(10'd8, 33);
        flip(10'd8, 0); flip(10'd8, 1);
        do_read(10'd8, 32'h8000_0002, 0, 1, 0, 1, "R7 double reset route");
        cfg_check(3'd3, 16'd3, "R6 both flags");

        // policy 0: raw, silent, no capture
        cfg_write(3'd3, 8'h03);
        cfg_write(3'd1, 8'h00);
        bus_write(10'd9, 32'h0000_0000);
        flip(10'd9, 10); flip(10'd9, 11);
        do_read(10'd9, 32'h0000_0C00, 0, 0, 0, 0, "R5 policy 0 raw");
        cfg_check(3'd3, 16'd0, "R5 policy 0 no flags");
        cfg_check(3'd4, 16'd8, "R5 policy 0 no capture");

        // injection, range 0 bit 13
        cfg_write(3'd1, 8'h01);
        cfg_write(3'd2, 8'h35);
        bus_write(10'd20, 32'h1111_2222);
        cfg_write(3'd2, 8'h00);
        do_read(10'd20, 32'h1111_2222, 1, 0, 0, 0, "R8 range 0 injected corrected");
        cfg_write(3'd1, 8'h00);
        do_read(10'd20, 32'h1111_0222, 0, 0, 0, 0, "R8 range 0 flips data bit 13");
        // range 1 bit 4
        cfg_write(3'd1, 8'h01);
        cfg_write(3'd2, 8'h13);
        bus_write(10'd21, 32'h3333_4444);
        cfg_write(3'd2, 8'h00);
        do_read(10'd21, 32'h3333_4444, 1, 0, 0, 0, "R8 range 1 check bit");
        // range 1 out of span
        cfg_write(3'd2, 8'h27);
        bus_write(10'd22, 32'h7777_8888);
        cfg_write(3'd2, 8'h00);
        do_read(10'd22, 32'h7777_8888, 0, 0, 0, 0, "R8 range 1 beyond span");
        // enable off
        cfg_write(3'd2, 8'h34);
        bus_write(10'd23, 32'h9999_0000);
        do_read(10'd23, 32'h9999_0000, 0, 0, 0, 0, "R8 enable off");
        cfg_write(3'd2, 8'h00);

        repeat (4) @(negedge clk);
        check("R2 all reads returned", exp_q.size(), 32'd0);
        finished = 1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule